// File: doc/BRIEF.md
# DMA Channel Request Enable and Service Request Merge

This block keeps one hardware-request enable flag per channel of a four-channel DMA controller. It uses those flags to filter the request lines that come from peripherals. Software can change the flags in two ways:

- A whole-word write replaces every flag at once.
- A set port or a clear port changes one channel, or all channels, without a read-modify-write.

The filtered hardware requests are ORed with software start pulses and channel-link pulses. The result goes through one register and becomes the per-channel service request sent to the arbiter. The enable flags never hold back a software or link request.

All pins are plain control signals sampled on each clock edge. Nothing here is a data stream, so there is no valid/ready handshake and no back-pressure. Each write strobe acts on the edge where it is high, and the request vectors are level-sampled.

Top module: `dma_req_enable`

## Requirements
- R1: `en_rd_data[3:0]` shows the current enable flag of channels 3..0. Bit n belongs to channel n.
- R2: `en_rd_data[31:4]` always reads zero. Data written into those bits has no effect on any flag.
- R3: After reset, all enable flags and all `svc_req` bits are zero.
- R4: When `bmp_wr_en` is high on an edge, the flags take the value of `bmp_wr_data[3:0]` after that edge.
- R5: A set-port write with `set_wr_data[6]`=0 sets the flag of the channel numbered by `set_wr_data[1:0]`. With bit 6 = 1 it sets every flag. All other bits of the port are ignored, and untargeted flags keep their value.
- R6: A clear-port write behaves like a set-port write, using `clr_wr_data[1:0]` and `clr_wr_data[6]`, but it clears the targeted flags.
- R7: When the set and clear ports target the same channel on the same edge, that flag ends cleared. A full-bitmap write on that edge overrides both ports completely.
- R8: A hardware request raises service for its channel only while that channel's flag is set. The flag used is the value held before the same edge.
- R9: `sw_start` and `link_req` raise service for their channel whatever the flag holds.
- R10: `svc_req` is registered. The value after edge k is computed from the inputs and flags sampled at edge k, and it stays zero when none of those requests is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bmp_wr_en | input | 1 | Full-bitmap write strobe |
| bmp_wr_data | input | 32 | Full-bitmap write value; bits 3:0 used |
| set_wr_en | input | 1 | Set-port write strobe |
| set_wr_data | input | 8 | Set-port value: channel in 1:0, all-channels in 6 |
| clr_wr_en | input | 1 | Clear-port write strobe |
| clr_wr_data | input | 8 | Clear-port value: channel in 1:0, all-channels in 6 |
| en_rd_data | output | 32 | Read view of the enable flags |
| hw_req | input | 4 | Peripheral request lines |
| sw_start | input | 4 | Software start requests |
| link_req | input | 4 | Channel-link requests |
| svc_req | output | 4 | Registered service requests to the arbiter |

## Verification
The bench builds the block with its defaults: four channels, a 32-bit read word, an 8-bit command port and bit 6 as the all-channels flag. These defaults make every channel number, the all-channels path and all 28 reserved read bits reachable.

Directed steps cover simultaneous set/clear collisions, a bitmap write that overrides both ports, and requests that arrive on the same edge as an enable change. Random traffic on all inputs then runs against a behavioural model for several hundred cycles.

// File: rtl/dmaen_pkg.sv
package dmaen_pkg;
  parameter int unsigned DEF_NUM_CH  = 4;
  parameter int unsigned DEF_REG_W   = 32;
  parameter int unsigned DEF_CMD_W   = 8;
  parameter int unsigned DEF_ALL_BIT = 6;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dmaen_decode.sv
module dmaen_decode
  import dmaen_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned CMD_W   = DEF_CMD_W,
  parameter int unsigned ALL_BIT = DEF_ALL_BIT
) (
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  cmd,
  output logic [NUM_CH-1:0] mask
);
  localparam int unsigned SEL_W = sel_width(NUM_CH);

  logic [SEL_W-1:0] sel;
  logic             all_ch;
  logic             unused_cmd;

  assign sel        = cmd[SEL_W-1:0];
  assign all_ch     = cmd[ALL_BIT];
  assign unused_cmd = ^cmd;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign mask[g] = wr_en & (all_ch | (sel == SEL_W'(g)));
  end

  always_comb begin
    if (wr_en && !all_ch) begin
      a_r5_one_target: assert ($countones(mask) <= 1);
    end
    if (!wr_en) begin
      a_r6_idle_no_mask: assert (mask == '0);
    end
  end
endmodule

// File: rtl/dmaen_bitmap.sv
module dmaen_bitmap
  import dmaen_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned REG_W  = DEF_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bmp_wr,
  input  logic [REG_W-1:0]  bmp_data,
  input  logic [NUM_CH-1:0] set_mask,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] en
);
  logic [NUM_CH-1:0] en_nxt;
  logic              unused_hi;

  assign unused_hi = ^bmp_data;

  always_comb begin
    if (bmp_wr) en_nxt = bmp_data[NUM_CH-1:0];
    else        en_nxt = (en | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= en_nxt;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r5_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask[g] && !clr_mask[g] && !bmp_wr) |=> en[g]);
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[g] && !bmp_wr) |=> !en[g]);
    a_r5_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_mask[g] && !clr_mask[g] && !bmp_wr) |=> $stable(en[g]));
    a_r4_bitmap_load: assert property (@(posedge clk) disable iff (!rst_n)
      bmp_wr |=> (en[g] == $past(bmp_data[g])));
  end
endmodule

// File: rtl/dmaen_req_merge.sv
module dmaen_req_merge
  import dmaen_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_start,
  input  logic [NUM_CH-1:0] link_req,
  output logic [NUM_CH-1:0] svc_req
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (hw_req[g] & en[g]) | sw_start[g] | link_req[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) svc_req[g] <= 1'b0;
      else        svc_req[g] <= hit;
    end

    a_r9_sw_link_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start[g] || link_req[g]) |=> svc_req[g]);
    a_r8_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[g] && !sw_start[g] && !link_req[g]) |=> !svc_req[g]);
    a_r8_gated_on: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && hw_req[g]) |=> svc_req[g]);
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_req[g] && !sw_start[g] && !link_req[g]) |=> !svc_req[g]);
  end
endmodule

// File: rtl/dma_req_enable.sv
module dma_req_enable
  import dmaen_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned REG_W   = DEF_REG_W,
  parameter int unsigned CMD_W   = DEF_CMD_W,
  parameter int unsigned ALL_BIT = DEF_ALL_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bmp_wr_en,
  input  logic [REG_W-1:0]  bmp_wr_data,
  input  logic              set_wr_en,
  input  logic [CMD_W-1:0]  set_wr_data,
  input  logic              clr_wr_en,
  input  logic [CMD_W-1:0]  clr_wr_data,
  output logic [REG_W-1:0]  en_rd_data,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic [NUM_CH-1:0] sw_start,
  input  logic [NUM_CH-1:0] link_req,
  output logic [NUM_CH-1:0] svc_req
);
  localparam int unsigned PAD_W = REG_W - NUM_CH;

  logic [NUM_CH-1:0] set_mask;
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] en;

  dmaen_decode #(.NUM_CH(NUM_CH), .CMD_W(CMD_W), .ALL_BIT(ALL_BIT)) u_set_dec (
    .wr_en(set_wr_en), .cmd(set_wr_data), .mask(set_mask));

  dmaen_decode #(.NUM_CH(NUM_CH), .CMD_W(CMD_W), .ALL_BIT(ALL_BIT)) u_clr_dec (
    .wr_en(clr_wr_en), .cmd(clr_wr_data), .mask(clr_mask));

  dmaen_bitmap #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_bitmap (
    .clk(clk), .rst_n(rst_n), .bmp_wr(bmp_wr_en), .bmp_data(bmp_wr_data),
    .set_mask(set_mask), .clr_mask(clr_mask), .en(en));

  dmaen_req_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk(clk), .rst_n(rst_n), .en(en), .hw_req(hw_req), .sw_start(sw_start),
    .link_req(link_req), .svc_req(svc_req));

  assign en_rd_data = {{PAD_W{1'b0}}, en};

  a_r3_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (svc_req == '0 || rst_n));
endmodule

// File: tb/dma_req_enable_bench.sv
`timescale 1ns/1ps
module dma_req_enable_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bmp_wr_en = 1'b0;
  logic [31:0] bmp_wr_data = '0;
  logic        set_wr_en = 1'b0;
  logic [7:0]  set_wr_data = '0;
  logic        clr_wr_en = 1'b0;
  logic [7:0]  clr_wr_data = '0;
  logic [31:0] en_rd_data;
  logic [3:0]  hw_req = '0;
  logic [3:0]  sw_start = '0;
  logic [3:0]  link_req = '0;
  logic [3:0]  svc_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0] m_en = '0;
  logic [3:0] m_svc = '0;

  always #2 clk = ~clk;

  dma_req_enable u_dma_req_enable (
    .clk(clk), .rst_n(rst_n),
    .bmp_wr_en(bmp_wr_en), .bmp_wr_data(bmp_wr_data),
    .set_wr_en(set_wr_en), .set_wr_data(set_wr_data),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .en_rd_data(en_rd_data),
    .hw_req(hw_req), .sw_start(sw_start), .link_req(link_req),
    .svc_req(svc_req));

  function automatic logic [3:0] port_mask(input logic wr, input logic [7:0] d);
    if (!wr) return 4'h0;
    if (d[6]) return 4'hF;
    return 4'h1 << d[1:0];
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en  = '0;
      m_svc = '0;
    end else begin
      logic [3:0] t;
      m_svc = (hw_req & m_en) | sw_start | link_req;
      if (bmp_wr_en) t = bmp_wr_data[3:0];
      else begin
        t = m_en | port_mask(set_wr_en, set_wr_data);
        t = t & ~port_mask(clr_wr_en, clr_wr_data);
      end
      m_en = t;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    check(en_rd_data == {28'h0, m_en}, "R1 R2 enable view", en_rd_data, {28'h0, m_en});
    check(svc_req == m_svc, "R10 svc vs model", {28'h0, svc_req}, {28'h0, m_svc});
  endtask

  task automatic idle();
    bmp_wr_en = 0; set_wr_en = 0; clr_wr_en = 0;
    hw_req = 0; sw_start = 0; link_req = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(en_rd_data == 0, "R3 reset enable", en_rd_data, 0);
    check(svc_req == 0, "R3 reset svc", {28'h0, svc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R2: full write with reserved bits set
    bmp_wr_en = 1; bmp_wr_data = 32'hFFFF_FFF5; step();
    check(en_rd_data == 32'h5, "R2 R4 bitmap load", en_rd_data, 32'h5);

    // R5: set channel 1 with noise in ignored bits
    set_wr_en = 1; set_wr_data = 8'hBD; step();
    check(en_rd_data == 32'h7, "R5 set one", en_rd_data, 32'h7);

    // R6: clear channel 0
    clr_wr_en = 1; clr_wr_data = 8'h00; step();
    check(en_rd_data == 32'h6, "R6 clear one", en_rd_data, 32'h6);

    // R7: set and clear same channel 3
    set_wr_en = 1; set_wr_data = 8'h03; clr_wr_en = 1; clr_wr_data = 8'h03; step();
    check(en_rd_data == 32'h6, "R7 clear wins", en_rd_data, 32'h6);

    // R7: bitmap beats both ports
    bmp_wr_en = 1; bmp_wr_data = 32'h9;
    set_wr_en = 1; set_wr_data = 8'h42; clr_wr_en = 1; clr_wr_data = 8'h00; step();
    check(en_rd_data == 32'h9, "R7 bitmap priority", en_rd_data, 32'h9);

    // R5 / R6 all-channel forms
    set_wr_en = 1; set_wr_data = 8'h40; clr_wr_en = 1; clr_wr_data = 8'h02; step();
    check(en_rd_data == 32'hB, "R5 set all minus clear", en_rd_data, 32'hB);
    clr_wr_en = 1; clr_wr_data = 8'h41; step();
    check(en_rd_data == 32'h0, "R6 clear all", en_rd_data, 32'h0);

    // R8: hardware request while disabled, then enabled
    hw_req = 4'hF; step();
    check(svc_req == 4'h0, "R8 gated off", {28'h0, svc_req}, 0);
    bmp_wr_en = 1; bmp_wr_data = 32'h4; hw_req = 4'hF; step();
    check(svc_req == 4'h0, "R8 old flag same edge", {28'h0, svc_req}, 0);
    hw_req = 4'hF; step();
    check(svc_req == 4'h4, "R8 gated on", {28'h0, svc_req}, 32'h4);

    // R9: software and link bypass enable
    sw_start = 4'h1; link_req = 4'h8; step();
    check(svc_req == 4'h9, "R9 bypass", {28'h0, svc_req}, 32'h9);
    step();
    check(svc_req == 4'h0, "R10 drop after one cycle", {28'h0, svc_req}, 0);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      bmp_wr_en   = ($urandom_range(0, 7) == 0);
      bmp_wr_data = $urandom;
      set_wr_en   = $urandom_range(0, 1);
      set_wr_data = 8'($urandom);
      clr_wr_en   = $urandom_range(0, 1);
      clr_wr_data = 8'($urandom);
      hw_req      = 4'($urandom);
      sw_start    = 4'($urandom) & 4'($urandom);
      link_req    = 4'($urandom) & 4'($urandom);
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule